// File: doc/BRIEF.md
# Nibble-Addressed Multi-Purpose Pointer

This block holds a wide pointer that a 4-bit processor core builds one nibble at a time. The pointer is spread over six register slots. Slots 0 to 4 each carry four pointer bits, lowest bits first. Slot 5 carries only the top bit in its bit 0. A parameter selects an 18-bit or a 21-bit pointer. Bits above the implemented width cannot be written and read back as zero.

Dedicated instruction strobes, one bit each in a one-hot vector, hand a fixed slice of the pointer to a consumer unit. A consumer gets either a short field or the whole pointer, and sees a registered data bus plus a one-cycle load pulse. One strobe works the other way and loads an external 4-bit bank value into pointer bits 11:8.

A 24-bit serial-flash address register is filled from pointer bits 11:0 in two halves, high and low. Two read-back strobes copy either half of that address into pointer bits 11:0, so software can inspect it through the nibble slots.

Top module: `nib_pointer`

## Requirements
- R1: After reset the pointer, the flash address, every consumer data bus and every load pulse are zero.
- R2: A register write to slot a (0 to 4) replaces pointer bits 4a+3:4a with the written nibble at the next clock edge. A write to slot 5 replaces bit 20 with data bit 0. `reg_rdata` shows the same mapping combinationally for `reg_addr`.
- R3: Slot 5 always reads bits 3:1 as 0. Slots 6 and 7 read as 0, and writes to them change nothing.
- R4: With `PTR_W`=18, pointer bits 20:18 cannot be written and read back as 0 (slot 4 bits 3:2 and slot 5 bit 0).
- R5: Strobe bit 0 loads pointer bits 11:0 into `phase_out`. Strobe bit 1 loads bits 7:0 into `env_out`. Each output's load pulse is high for the cycle after the strobe edge. Each load uses the pointer value held before that edge.
- R6: Strobe bit 3 loads pointer bits 5:0 into `xm_lo_out`. Strobe bit 4 loads bits 13:8 into `xm_hi_out`. Each output has its own load pulse.
- R7: Strobe bit 5 loads the whole implemented pointer into `full_out` and pulses `full_ld`.
- R8: Strobe bit 2 writes `bank_nib` into pointer bits 11:8 and leaves all other pointer bits unchanged.
- R9: Strobe bit 6 copies pointer bits 11:0 into `spi_addr` 23:12. Strobe bit 7 copies them into `spi_addr` 11:0. The other half keeps its value.
- R10: Strobe bit 8 copies `spi_addr` 23:12 into pointer bits 11:0. Strobe bit 9 copies `spi_addr` 11:0 into pointer bits 11:0. Pointer bits above 11 keep their value.
- R11: When a strobe and a register write target the same pointer bit in one cycle, the strobe's value wins. Register-write bits that the strobe does not touch still take effect.
- R12: A strobe vector with more than one bit set has no effect: no load pulse, no pointer change from a strobe, and no flash address change. A register write in that same cycle still applies.
- R13: Consumer data buses hold their value between strobes. A load pulse never lasts longer than one cycle per strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 3 | Slot select for read and write |
| reg_wdata | input | 4 | Write nibble |
| reg_rdata | output | 4 | Read nibble of selected slot |
| ins_strobe | input | 10 | One-hot instruction strobes (bit positions per R5 to R10) |
| bank_nib | input | 4 | Bank value for strobe bit 2 |
| phase_out | output | 12 | Phase-increment consumer data |
| phase_ld | output | 1 | Phase data load pulse |
| env_out | output | 8 | Envelope consumer data |
| env_ld | output | 1 | Envelope load pulse |
| xm_lo_out | output | 6 | Low extended-mode field |
| xm_lo_ld | output | 1 | Low extended-mode load pulse |
| xm_hi_out | output | 6 | High extended-mode field |
| xm_hi_ld | output | 1 | High extended-mode load pulse |
| full_out | output | PTR_W | Whole pointer for full-width consumers |
| full_ld | output | 1 | Full pointer load pulse |
| spi_addr | output | 24 | Staged serial-flash address |

## Verification
A corrupted pointer bit shows up at once on `reg_rdata` for its slot. It also shows up one edge later on any consumer bus whose slice covers it, so sweeping every slot with every nibble value, in both width variants, exposes a wrong slot mapping or a writable phantom bit on the very next read. A wrong half-select in the flash address path surfaces on `spi_addr` one edge after the strobe. It also surfaces in the pointer slots one edge after a read-back strobe, where the untouched upper bits show whether the copy spilled over. Random streams mixing legal, multi-hot and idle strobes with same-cycle register writes check priority and the one-cycle load pulses edge by edge.

// File: rtl/nib_pointer_pkg.sv
package nib_pointer_pkg;
    localparam int NIB_W    = 4;
    localparam int SLOT_N   = 6;
    localparam int SLOT_AW  = 3;
    localparam int SPI_W    = 24;
    localparam int HALF_W   = SPI_W / 2;
    localparam int ENV_W    = 8;
    localparam int XM_W     = 6;
    localparam int XM_HI_LSB = 8;
    localparam int BANK_LSB = 8;
    localparam int OP_N     = 10;
    localparam int LD_N     = 5;

    // strobe bit positions
    localparam int OP_PHASE     = 0;
    localparam int OP_ENV       = 1;
    localparam int OP_BANK      = 2;
    localparam int OP_XM_LO     = 3;
    localparam int OP_XM_HI     = 4;
    localparam int OP_FULL      = 5;
    localparam int OP_SPI_HI_LD = 6;
    localparam int OP_SPI_LO_LD = 7;
    localparam int OP_SPI_HI_RD = 8;
    localparam int OP_SPI_LO_RD = 9;

    // load pulse positions inside the transfer unit
    localparam int LD_PHASE = 0;
    localparam int LD_ENV   = 1;
    localparam int LD_XM_LO = 2;
    localparam int LD_XM_HI = 3;
    localparam int LD_FULL  = 4;
endpackage

// File: rtl/nib_pointer_decode.sv
module nib_pointer_decode
    import nib_pointer_pkg::*;
(
    input  logic [OP_N-1:0] ins_raw,
    output logic [OP_N-1:0] ins_sel
);
    logic single_hot;

    always_comb begin
        single_hot = ($countones(ins_raw) == 1);
        ins_sel    = single_hot ? ins_raw : '0;
    end
endmodule

// File: rtl/nib_pointer_store.sv
module nib_pointer_store
    import nib_pointer_pkg::*;
#(
    parameter int PTR_W = 21
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SLOT_AW-1:0] wr_slot,
    input  logic [NIB_W-1:0]   wr_nib,
    input  logic [SLOT_AW-1:0] rd_slot,
    output logic [NIB_W-1:0]   rd_nib,
    input  logic               low_en,
    input  logic [HALF_W-1:0]  low_val,
    input  logic               bank_en,
    input  logic [NIB_W-1:0]   bank_val,
    output logic [PTR_W-1:0]   ptr_o
);
    localparam int WIDE_W = NIB_W * SLOT_N;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } store_t;

    store_t             st_d;
    store_t             st_q;
    logic [WIDE_W-1:0]  wide;

    always_comb begin
        st_d = st_q;
        // register port: each implemented bit belongs to slot b/NIB_W
        for (int b = 0; b < PTR_W; b++) begin
            if (wr_en && (wr_slot == SLOT_AW'(b / NIB_W))) begin
                st_d.ptr[b] = wr_nib[b % NIB_W];
            end
        end
        // instruction writes come last so they win on overlap
        if (low_en) begin
            st_d.ptr[HALF_W-1:0] = low_val;
        end
        if (bank_en) begin
            st_d.ptr[BANK_LSB +: NIB_W] = bank_val;
        end

        wide = '0;
        wide[PTR_W-1:0] = st_q.ptr;
        rd_nib = '0;
        for (int k = 0; k < SLOT_N; k++) begin
            if (rd_slot == SLOT_AW'(k)) begin
                rd_nib = wide[k*NIB_W +: NIB_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o = st_q.ptr;
endmodule

// File: rtl/nib_pointer_xfer.sv
module nib_pointer_xfer
    import nib_pointer_pkg::*;
#(
    parameter int PTR_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LD_N-1:0]  ld_req,
    input  logic [PTR_W-1:0] ptr,
    output logic [HALF_W-1:0] phase_o,
    output logic [ENV_W-1:0] env_o,
    output logic [XM_W-1:0]  xm_lo_o,
    output logic [XM_W-1:0]  xm_hi_o,
    output logic [PTR_W-1:0] full_o,
    output logic [LD_N-1:0]  ld_o
);
    typedef struct packed {
        logic [HALF_W-1:0] phase;
        logic [ENV_W-1:0]  env;
        logic [XM_W-1:0]   xm_lo;
        logic [XM_W-1:0]   xm_hi;
        logic [PTR_W-1:0]  full;
        logic [LD_N-1:0]   ld;
    } xfer_t;

    xfer_t xf_d;
    xfer_t xf_q;

    always_comb begin
        xf_d    = xf_q;
        xf_d.ld = '0;
        if (ld_req[LD_PHASE]) begin
            xf_d.phase        = ptr[HALF_W-1:0];
            xf_d.ld[LD_PHASE] = 1'b1;
        end
        if (ld_req[LD_ENV]) begin
            xf_d.env        = ptr[ENV_W-1:0];
            xf_d.ld[LD_ENV] = 1'b1;
        end
        if (ld_req[LD_XM_LO]) begin
            xf_d.xm_lo        = ptr[XM_W-1:0];
            xf_d.ld[LD_XM_LO] = 1'b1;
        end
        if (ld_req[LD_XM_HI]) begin
            xf_d.xm_hi        = ptr[XM_HI_LSB +: XM_W];
            xf_d.ld[LD_XM_HI] = 1'b1;
        end
        if (ld_req[LD_FULL]) begin
            xf_d.full        = ptr;
            xf_d.ld[LD_FULL] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xf_q <= '0;
        end else begin
            xf_q <= xf_d;
        end
    end

    assign phase_o = xf_q.phase;
    assign env_o   = xf_q.env;
    assign xm_lo_o = xf_q.xm_lo;
    assign xm_hi_o = xf_q.xm_hi;
    assign full_o  = xf_q.full;
    assign ld_o    = xf_q.ld;
endmodule

// File: rtl/nib_pointer_spi.sv
module nib_pointer_spi
    import nib_pointer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_ld,
    input  logic              lo_ld,
    input  logic [HALF_W-1:0] src,
    output logic [SPI_W-1:0]  addr_o
);
    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } spi_t;

    spi_t sp_d;
    spi_t sp_q;

    always_comb begin
        sp_d = sp_q;
        if (hi_ld) begin
            sp_d.hi = src;
        end
        if (lo_ld) begin
            sp_d.lo = src;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else begin
            sp_q <= sp_d;
        end
    end

    assign addr_o = {sp_q.hi, sp_q.lo};
endmodule

// File: rtl/nib_pointer.sv
module nib_pointer
    import nib_pointer_pkg::*;
#(
    parameter int PTR_W = 21
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [SLOT_AW-1:0] reg_addr,
    input  logic [NIB_W-1:0]   reg_wdata,
    output logic [NIB_W-1:0]   reg_rdata,
    input  logic [OP_N-1:0]    ins_strobe,
    input  logic [NIB_W-1:0]   bank_nib,
    output logic [HALF_W-1:0]  phase_out,
    output logic               phase_ld,
    output logic [ENV_W-1:0]   env_out,
    output logic               env_ld,
    output logic [XM_W-1:0]    xm_lo_out,
    output logic               xm_lo_ld,
    output logic [XM_W-1:0]    xm_hi_out,
    output logic               xm_hi_ld,
    output logic [PTR_W-1:0]   full_out,
    output logic               full_ld,
    output logic [SPI_W-1:0]   spi_addr
);
    logic [OP_N-1:0]   sel;
    logic [PTR_W-1:0]  ptr_now;
    logic [LD_N-1:0]   ld_req;
    logic [LD_N-1:0]   ld_pulse;
    logic              readback_en;
    logic [HALF_W-1:0] readback_val;

    nib_pointer_decode u_decode (
        .ins_raw (ins_strobe),
        .ins_sel (sel)
    );

    always_comb begin
        readback_en  = sel[OP_SPI_HI_RD] | sel[OP_SPI_LO_RD];
        readback_val = sel[OP_SPI_HI_RD] ? spi_addr[SPI_W-1:HALF_W]
                                         : spi_addr[HALF_W-1:0];
        ld_req           = '0;
        ld_req[LD_PHASE] = sel[OP_PHASE];
        ld_req[LD_ENV]   = sel[OP_ENV];
        ld_req[LD_XM_LO] = sel[OP_XM_LO];
        ld_req[LD_XM_HI] = sel[OP_XM_HI];
        ld_req[LD_FULL]  = sel[OP_FULL];
    end

    nib_pointer_store #(.PTR_W(PTR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .wr_slot  (reg_addr),
        .wr_nib   (reg_wdata),
        .rd_slot  (reg_addr),
        .rd_nib   (reg_rdata),
        .low_en   (readback_en),
        .low_val  (readback_val),
        .bank_en  (sel[OP_BANK]),
        .bank_val (bank_nib),
        .ptr_o    (ptr_now)
    );

    nib_pointer_xfer #(.PTR_W(PTR_W)) u_xfer (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_req  (ld_req),
        .ptr     (ptr_now),
        .phase_o (phase_out),
        .env_o   (env_out),
        .xm_lo_o (xm_lo_out),
        .xm_hi_o (xm_hi_out),
        .full_o  (full_out),
        .ld_o    (ld_pulse)
    );

    nib_pointer_spi u_spi (
        .clk    (clk),
        .rst_n  (rst_n),
        .hi_ld  (sel[OP_SPI_HI_LD]),
        .lo_ld  (sel[OP_SPI_LO_LD]),
        .src    (ptr_now[HALF_W-1:0]),
        .addr_o (spi_addr)
    );

    assign phase_ld = ld_pulse[LD_PHASE];
    assign env_ld   = ld_pulse[LD_ENV];
    assign xm_lo_ld = ld_pulse[LD_XM_LO];
    assign xm_hi_ld = ld_pulse[LD_XM_HI];
    assign full_ld  = ld_pulse[LD_FULL];
endmodule

// File: rtl/nib_pointer_chk.sv
module nib_pointer_chk
    import nib_pointer_pkg::*;
#(
    parameter int PTR_W = 21
) (
    input logic               clk,
    input logic               rst_n,
    input logic [OP_N-1:0]    ins_strobe,
    input logic [SLOT_AW-1:0] reg_addr,
    input logic               reg_wr,
    input logic [NIB_W-1:0]   reg_rdata,
    input logic [PTR_W-1:0]   ptr_now,
    input logic [SPI_W-1:0]   spi_addr,
    input logic [HALF_W-1:0]  phase_out,
    input logic               phase_ld,
    input logic               env_ld,
    input logic               xm_lo_ld,
    input logic               xm_hi_ld,
    input logic [PTR_W-1:0]   full_out,
    input logic               full_ld
);
    localparam logic [OP_N-1:0] ONE = OP_N'(1);

    a_r5_phase_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_strobe == (ONE << OP_PHASE)) |=> (phase_ld && phase_out == $past(ptr_now[HALF_W-1:0])));

    a_r7_full_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_strobe == (ONE << OP_FULL)) |=> (full_ld && full_out == $past(ptr_now)));

    a_r9_hi_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_strobe == (ONE << OP_SPI_HI_LD)) |=>
        (spi_addr[SPI_W-1:HALF_W] == $past(ptr_now[HALF_W-1:0]) &&
         spi_addr[HALF_W-1:0] == $past(spi_addr[HALF_W-1:0])));

    a_r10_lo_read: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_strobe == (ONE << OP_SPI_LO_RD)) |=> (ptr_now[HALF_W-1:0] == $past(spi_addr[HALF_W-1:0])));

    a_r10_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_strobe == (ONE << OP_SPI_HI_RD) && !reg_wr) |=>
        (ptr_now[PTR_W-1:HALF_W] == $past(ptr_now[PTR_W-1:HALF_W])));

    a_r12_multi_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ins_strobe) > 1) |=>
        (!(phase_ld || env_ld || xm_lo_ld || xm_hi_ld || full_ld) && $stable(spi_addr)));

    a_r3_slot5_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == SLOT_AW'(5)) |-> (reg_rdata[NIB_W-1:1] == '0));

    a_r13_no_stray_ld: assert property (@(posedge clk) disable iff (!rst_n)
        (!ins_strobe[OP_ENV]) |=> !env_ld);
endmodule

bind nib_pointer nib_pointer_chk #(.PTR_W(PTR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ins_strobe (ins_strobe),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rdata  (reg_rdata),
    .ptr_now    (ptr_now),
    .spi_addr   (spi_addr),
    .phase_out  (phase_out),
    .phase_ld   (phase_ld),
    .env_ld     (env_ld),
    .xm_lo_ld   (xm_lo_ld),
    .xm_hi_ld   (xm_hi_ld),
    .full_out   (full_out),
    .full_ld    (full_ld)
);

// File: tb/nib_pointer_tb_top.sv
module nib_pointer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [3:0] reg_wdata = '0;
    logic [9:0] ins = '0;
    logic [3:0] bank_nib = '0;

    logic [3:0]  o_rd [2];
    logic [11:0] o_ph [2];
    logic [7:0]  o_en [2];
    logic [5:0]  o_x0 [2];
    logic [5:0]  o_x1 [2];
    logic [4:0]  o_ld [2];
    logic [23:0] o_sp [2];
    logic [20:0] o_fu0;
    logic [17:0] o_fu1;

    // expected state per variant: 0 -> 21 bits, 1 -> 18 bits
    logic [20:0] mp  [2];
    logic [23:0] ms  [2];
    logic [11:0] eph [2];
    logic [7:0]  een [2];
    logic [5:0]  ex0 [2];
    logic [5:0]  ex1 [2];
    logic [20:0] efu [2];
    logic [4:0]  eld [2];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nib_pointer #(.PTR_W(21)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(o_rd[0]), .ins_strobe(ins), .bank_nib(bank_nib),
        .phase_out(o_ph[0]), .phase_ld(o_ld[0][0]), .env_out(o_en[0]), .env_ld(o_ld[0][1]),
        .xm_lo_out(o_x0[0]), .xm_lo_ld(o_ld[0][2]), .xm_hi_out(o_x1[0]), .xm_hi_ld(o_ld[0][3]),
        .full_out(o_fu0), .full_ld(o_ld[0][4]), .spi_addr(o_sp[0])
    );

    nib_pointer #(.PTR_W(18)) dut_s_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(o_rd[1]), .ins_strobe(ins), .bank_nib(bank_nib),
        .phase_out(o_ph[1]), .phase_ld(o_ld[1][0]), .env_out(o_en[1]), .env_ld(o_ld[1][1]),
        .xm_lo_out(o_x0[1]), .xm_lo_ld(o_ld[1][2]), .xm_hi_out(o_x1[1]), .xm_hi_ld(o_ld[1][3]),
        .full_out(o_fu1), .full_ld(o_ld[1][4]), .spi_addr(o_sp[1])
    );

    function automatic int width_of(int v);
        return (v == 0) ? 21 : 18;
    endfunction

    task automatic chk(string tag, int v, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s (width %0d) actual=%0h expected=%0h", tag, width_of(v), act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    // expected update for one edge, from the requirement text
    task automatic model(int v, logic wr, logic [2:0] ad, logic [3:0] wd,
                         logic [9:0] op, logic [3:0] bk);
        logic [23:0] w;
        logic [23:0] msk;
        logic [20:0] old;
        logic [9:0]  s;
        msk = (24'd1 << width_of(v)) - 24'd1;
        old = mp[v];
        s   = ($countones(op) == 1) ? op : 10'd0;
        w   = {3'b000, old};
        if (wr && ad < 3'd6) w[int'(ad)*4 +: 4] = wd;
        w = w & msk;
        if (s[8]) w[11:0] = ms[v][23:12];
        if (s[9]) w[11:0] = ms[v][11:0];
        if (s[2]) w[11:8] = bk;
        if (s[6]) ms[v][23:12] = old[11:0];
        if (s[7]) ms[v][11:0]  = old[11:0];
        if (s[0]) eph[v] = old[11:0];
        if (s[1]) een[v] = old[7:0];
        if (s[3]) ex0[v] = old[5:0];
        if (s[4]) ex1[v] = old[13:8];
        if (s[5]) efu[v] = old;
        eld[v] = {s[5], s[4], s[3], s[1], s[0]};
        mp[v] = w[20:0];
    endtask

    task automatic check_outputs(string ctx);
        for (int v = 0; v < 2; v++) begin
            chk({ctx, " R5 phase_out"}, v, 32'(o_ph[v]), 32'(eph[v]));
            chk({ctx, " R5 env_out"}, v, 32'(o_en[v]), 32'(een[v]));
            chk({ctx, " R6 xm_lo_out"}, v, 32'(o_x0[v]), 32'(ex0[v]));
            chk({ctx, " R6 xm_hi_out"}, v, 32'(o_x1[v]), 32'(ex1[v]));
            chk({ctx, " R7 full_out"}, v, (v == 0) ? 32'(o_fu0) : 32'(o_fu1), 32'(efu[v]));
            chk({ctx, " R13 load pulses"}, v, 32'(o_ld[v]), 32'(eld[v]));
            chk({ctx, " R9 spi_addr"}, v, 32'(o_sp[v]), 32'(ms[v]));
        end
    endtask

    task automatic step(string ctx, logic wr, logic [2:0] ad, logic [3:0] wd,
                        logic [9:0] op, logic [3:0] bk);
        @(negedge clk);
        reg_wr = wr; reg_addr = ad; reg_wdata = wd; ins = op; bank_nib = bk;
        for (int v = 0; v < 2; v++) model(v, wr, ad, wd, op, bk);
        @(posedge clk);
        #1;
        check_outputs(ctx);
    endtask

    // idle reads of every slot; no clock-edge effect since nothing is driven
    task automatic readback(string ctx);
        logic [23:0] wide;
        @(negedge clk);
        reg_wr = 1'b0; ins = '0;
        for (int a = 0; a < 8; a++) begin
            reg_addr = 3'(a);
            #1;
            for (int v = 0; v < 2; v++) begin
                wide = {3'b000, mp[v]};
                chk({ctx, " slot read"}, v, 32'(o_rd[v]), (a < 6) ? 32'(wide[a*4 +: 4]) : 32'd0);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] lf;
        logic [9:0]  op;
        for (int v = 0; v < 2; v++) begin
            mp[v] = '0; ms[v] = '0; eph[v] = '0; een[v] = '0;
            ex0[v] = '0; ex1[v] = '0; efu[v] = '0; eld[v] = '0;
        end

        // reset state
        repeat (3) @(posedge clk);
        #1;
        check_outputs("R1 reset");
        readback("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // every slot with every nibble, both widths
        for (int a = 0; a < 8; a++) begin
            for (int d = 0; d < 16; d++) begin
                step("R2 R3 R4 sweep", 1'b1, 3'(a), 4'(d), 10'd0, 4'd0);
                readback("R2 R3 R4 sweep");
            end
        end

        // set pointer to a known pattern, then each consumer transfer
        for (int a = 0; a < 6; a++) step("R2 setup", 1'b1, 3'(a), 4'(4'hA + a), 10'd0, 4'd0);
        step("R5 phase", 1'b0, 3'd0, 4'd0, 10'b1 << 0, 4'd0);
        step("R5 env", 1'b0, 3'd0, 4'd0, 10'b1 << 1, 4'd0);
        step("R6 xm lo", 1'b0, 3'd0, 4'd0, 10'b1 << 3, 4'd0);
        step("R6 xm hi", 1'b0, 3'd0, 4'd0, 10'b1 << 4, 4'd0);
        step("R7 full", 1'b0, 3'd0, 4'd0, 10'b1 << 5, 4'd0);
        step("R13 hold", 1'b0, 3'd0, 4'd0, 10'd0, 4'd0);

        // bank nibble into bits 11:8
        step("R8 bank", 1'b0, 3'd0, 4'd0, 10'b1 << 2, 4'h5);
        readback("R8 bank");

        // two-step flash address build
        step("R9 prep", 1'b1, 3'd0, 4'hC, 10'd0, 4'd0);
        step("R9 prep", 1'b1, 3'd1, 4'hB, 10'd0, 4'd0);
        step("R9 prep", 1'b1, 3'd2, 4'hA, 10'd0, 4'd0);
        step("R9 hi load", 1'b0, 3'd0, 4'd0, 10'b1 << 6, 4'd0);
        step("R9 prep", 1'b1, 3'd0, 4'h3, 10'd0, 4'd0);
        step("R9 prep", 1'b1, 3'd1, 4'h2, 10'd0, 4'd0);
        step("R9 prep", 1'b1, 3'd2, 4'h1, 10'd0, 4'd0);
        step("R9 lo load", 1'b0, 3'd0, 4'd0, 10'b1 << 7, 4'd0);
        for (int v = 0; v < 2; v++) chk("R9 assembled address", v, 32'(o_sp[v]), 32'h00ABC123);

        // read-back of each half keeps upper pointer bits
        step("R10 prep", 1'b1, 3'd3, 4'h6, 10'd0, 4'd0);
        step("R10 hi read", 1'b0, 3'd0, 4'd0, 10'b1 << 8, 4'd0);
        readback("R10 hi read");
        step("R10 lo read", 1'b0, 3'd0, 4'd0, 10'b1 << 9, 4'd0);
        readback("R10 lo read");

        // same-cycle conflicts
        step("R11 overlap", 1'b1, 3'd2, 4'hF, 10'b1 << 2, 4'h3);
        readback("R11 overlap");
        step("R11 disjoint", 1'b1, 3'd3, 4'h9, 10'b1 << 8, 4'd0);
        readback("R11 disjoint");

        // multi-hot strobes do nothing, register write still lands
        step("R12 multi", 1'b1, 3'd0, 4'h7, (10'b1 << 2) | (10'b1 << 0), 4'hE);
        readback("R12 multi");
        step("R12 multi spi", 1'b0, 3'd0, 4'd0, (10'b1 << 6) | (10'b1 << 9), 4'd0);
        readback("R12 multi spi");

        // pseudo-random mix
        lf = 32'h1F2E3D4C;
        for (int i = 0; i < 600; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            case (lf[3:2])
                2'd0:    op = (10'b1 << (lf[11:8] % 10)) | (10'b1 << (lf[15:12] % 10));
                2'd1:    op = 10'd0;
                default: op = 10'b1 << (lf[11:8] % 10);
            endcase
            step("R11 R12 random", lf[16], lf[19:17], lf[23:20], op, lf[27:24]);
            if (i % 50 == 0) readback("R2 R10 random");
        end
        step("R13 final idle", 1'b0, 3'd0, 4'd0, 10'd0, 4'd0);
        readback("R2 final");

        summary();
    end
endmodule